// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block models the slave side of a two-wire serial EEPROM. It watches the clock and data lines of an open-drain bus and acknowledges a single fixed select code, 1010000. It takes a two-byte memory address, high byte first, and then serves byte writes, page writes, current-address reads, random reads and sequential reads. An internal address pointer advances by one after every byte that is transferred. Both bus lines are modelled as a sampled input. Data is driven only through a pull-low enable, so `sda_oe_o = 1` places a 0 on the line.

Written bytes go into a page buffer. They reach the byte array only when the transfer ends with a STOP. Committing the buffer opens a self-timed busy window that lasts a fixed number of system-clock cycles. During that window the slave does not acknowledge its select code. A write-control input, active high, blocks programming. When it is high, data bytes receive no acknowledge and no busy window begins.

Top module: `serial_eeprom`

## Requirements
- R1: After reset `sda_oe_o` is 0 and every byte of the array reads as 8'hFF.
- R2: After a START, the first byte is acknowledged only when its upper seven bits are 1010000. Any other code leaves SDA released (no acknowledge) for every later bit until the next START.
- R3: The two address bytes after a write select (bit 0 = 0) are each acknowledged. The address is sent high byte first, and only its low log2(MEM_BYTES) bits are used (address 16'h8010 selects byte 16'h0010 at the default 1 KB depth).
- R4: In a byte write, the data byte is acknowledged, is written to the array only after a STOP, and reads back once the busy window has ended.
- R5: In a page write, the pointer advances only in its low six bits and wraps inside the same 64-byte page. The byte that follows 0x03F is stored at 0x000, and 0x040 is left unchanged.
- R6: Data bytes of a write that ends in a repeated START instead of a STOP are discarded. No busy window starts.
- R7: For BUSY_CYCLES system clocks after a commit begins, the select code receives no acknowledge.
- R8: While `wc_i` is 1, data bytes receive no acknowledge, the array is unchanged, and no busy window starts.
- R9: A random read, meaning a write select with the address, then a repeated START and a read select (bit 0 = 1), returns the byte at that address, MSB first.
- R10: A read continues from the pointer and advances by one per byte. It wraps from the last byte to 0. A master NoAck ends the read, and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| wc_i | input | 1 | Write control; 1 blocks programming |
| sda_oe_o | output | 1 | Pull-low enable for the data line |

## Verification
A table of single-byte writes and read-backs covers low, middle and top addresses, plus one address with set bits above the array depth. This set separates correct address truncation and byte placement from an off-by-one error or an ignored high byte. Directed sequences cover the remaining cases. A page write that crosses a page end separates wrap-in-page from a linear increment. A read over the last byte separates wrap-to-zero from overflow. A select sent right after a STOP, and the same select sent with write control high, separate a busy window that runs from one that is wrongly skipped. A wrong select code and a write aborted by a repeated START show that bus traffic is ignored and that discarded bytes do not reach the array.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WR, ST_RD
  } bus_st_e;

  localparam logic [6:0] DEV_CODE = 7'b1010000;
endpackage

// File: rtl/i2c_line_mon.sv
module i2c_line_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic sda_o
);
  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_sy[1];
      sda_q  <= sda_sy[1];
    end
  end

  assign scl_rise_o = scl_sy[1] & ~scl_q;
  assign scl_fall_o = ~scl_sy[1] & scl_q;
  // data edge while clock stays high
  assign start_o = scl_sy[1] & scl_q & sda_q & ~sda_sy[1];
  assign stop_o  = scl_sy[1] & scl_q & ~sda_q & sda_sy[1];
  assign sda_o   = sda_sy[1];
endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
  parameter int MEM_BYTES   = 1024,
  parameter int PAGE_BYTES  = 64,
  parameter int BUSY_CYCLES = 1000,
  localparam int ADDR_W = $clog2(MEM_BYTES),
  localparam int PIDX_W = $clog2(PAGE_BYTES),
  localparam int CNT_W  = $clog2(BUSY_CYCLES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              buf_we_i,
  input  logic [PIDX_W-1:0] buf_idx_i,
  input  logic [7:0]        buf_data_i,
  input  logic              discard_i,
  input  logic              commit_i,
  input  logic [ADDR_W-PIDX_W-1:0] page_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              busy_o
);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(BUSY_CYCLES - 1);
  localparam logic [CNT_W-1:0] PG_LIM = CNT_W'(PAGE_BYTES);

  logic [7:0]                mem  [MEM_BYTES];
  logic [7:0]                pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0]     vld;
  logic [ADDR_W-PIDX_W-1:0]  page_q;
  logic [CNT_W-1:0]          busy_cnt;
  logic                      busy;
  logic [PIDX_W-1:0]         cidx;

  assign cidx = busy_cnt[PIDX_W-1:0];

  always_ff @(posedge clk_i) begin
    if (buf_we_i && !busy) pbuf[buf_idx_i] <= buf_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
      vld      <= '0;
      page_q   <= '0;
      busy_cnt <= '0;
      busy     <= 1'b0;
    end else begin
      if (busy) begin
        // one buffered byte per cycle during the busy window
        if (busy_cnt < PG_LIM && vld[cidx]) mem[{page_q, cidx}] <= pbuf[cidx];
        if (busy_cnt == LAST) begin
          busy     <= 1'b0;
          busy_cnt <= '0;
          vld      <= '0;
        end else begin
          busy_cnt <= busy_cnt + 1'b1;
        end
      end else if (commit_i && |vld) begin
        busy     <= 1'b1;
        busy_cnt <= '0;
        page_q   <= page_i;
      end else if (discard_i) begin
        vld <= '0;
      end
      if (buf_we_i && !busy) vld[buf_idx_i] <= 1'b1;
    end
  end

  assign rd_data_o = mem[rd_addr_i];
  assign busy_o    = busy;
endmodule

// File: rtl/eeprom_bus_fsm.sv
module eeprom_bus_fsm
  import eeprom_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PIDX_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  input  logic              wc_i,
  input  logic              busy_i,
  input  logic [7:0]        rd_data_i,
  output logic              sda_oe_o,
  output bus_st_e           st_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              buf_we_o,
  output logic [PIDX_W-1:0] buf_idx_o,
  output logic [7:0]        buf_data_o,
  output logic              discard_o,
  output logic              commit_o,
  output logic [ADDR_W-PIDX_W-1:0] page_o
);
  localparam int AHI_W = ADDR_W - 8;

  bus_st_e           st, nxt;
  logic [3:0]        cnt;
  logic [7:0]        sh;
  logic [AHI_W-1:0]  addr_hi;
  logic [ADDR_W-1:0] ptr;
  logic              drive, mnack;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= ST_IDLE;
      nxt     <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      addr_hi <= '0;
      ptr     <= '0;
      drive   <= 1'b0;
      mnack   <= 1'b0;
    end else if (start_i) begin
      st    <= ST_DEV;
      cnt   <= '0;
      drive <= 1'b0;
    end else if (stop_i) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      drive <= 1'b0;
    end else if (st != ST_IDLE) begin
      if (scl_rise_i) begin
        cnt <= cnt + 1'b1;
        if (cnt < 4'd8 && st != ST_RD) sh <= {sh[6:0], sda_i};
        if (cnt == 4'd8 && st == ST_RD) mnack <= sda_i;
      end else if (scl_fall_i) begin
        if (cnt == 4'd8) begin
          // ninth bit slot opens
          unique case (st)
            ST_DEV: begin
              if (sh[7:1] == DEV_CODE && !busy_i) begin
                drive <= 1'b1;
                nxt   <= sh[0] ? ST_RD : ST_AHI;
              end else begin
                st    <= ST_IDLE;
                drive <= 1'b0;
              end
            end
            ST_AHI: begin
              drive   <= 1'b1;
              addr_hi <= sh[AHI_W-1:0];
              nxt     <= ST_ALO;
            end
            ST_ALO: begin
              drive <= 1'b1;
              ptr   <= {addr_hi, sh};
              nxt   <= ST_WR;
            end
            ST_WR: begin
              if (wc_i) begin
                st    <= ST_IDLE;
                drive <= 1'b0;
              end else begin
                drive <= 1'b1;
                ptr   <= {ptr[ADDR_W-1:PIDX_W], ptr[PIDX_W-1:0] + 1'b1};
                nxt   <= ST_WR;
              end
            end
            default: begin
              drive <= 1'b0;
              nxt   <= ST_RD;
            end
          endcase
        end else if (cnt == 4'd9) begin
          cnt <= '0;
          if (nxt == ST_RD && !(st == ST_RD && mnack)) begin
            st    <= ST_RD;
            sh    <= rd_data_i;
            drive <= ~rd_data_i[7];
            ptr   <= ptr + 1'b1;
          end else if (st == ST_RD) begin
            st    <= ST_IDLE;
            drive <= 1'b0;
          end else begin
            st    <= nxt;
            drive <= 1'b0;
          end
        end else if (st == ST_RD && cnt != 4'd0) begin
          sh    <= {sh[6:0], 1'b0};
          drive <= ~sh[6];
        end
      end
    end
  end

  assign sda_oe_o   = drive;
  assign st_o       = st;
  assign ptr_o      = ptr;
  assign buf_we_o   = scl_fall_i && cnt == 4'd8 && st == ST_WR && !wc_i && !start_i && !stop_i;
  assign buf_idx_o  = ptr[PIDX_W-1:0];
  assign buf_data_o = sh;
  assign discard_o  = start_i;
  assign commit_o   = stop_i && st == ST_WR;
  assign page_o     = ptr[ADDR_W-1:PIDX_W];
endmodule

// File: rtl/serial_eeprom.sv
module serial_eeprom
  import eeprom_pkg::*;
#(
  parameter int MEM_BYTES   = 1024,
  parameter int PAGE_BYTES  = 64,
  parameter int BUSY_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wc_i,
  output logic sda_oe_o
);
  localparam int ADDR_W = $clog2(MEM_BYTES);
  localparam int PIDX_W = $clog2(PAGE_BYTES);

  logic scl_rise, scl_fall, start_det, stop_det, sda_s, busy;
  logic buf_we, discard, commit;
  logic [PIDX_W-1:0]        buf_idx;
  logic [7:0]               buf_data, rd_data;
  logic [ADDR_W-1:0]        ptr;
  logic [ADDR_W-PIDX_W-1:0] page;
  bus_st_e                  st;

  i2c_line_mon u_mon (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det), .sda_o(sda_s)
  );

  eeprom_bus_fsm #(.ADDR_W(ADDR_W), .PIDX_W(PIDX_W)) u_fsm (
    .clk_i, .rst_ni,
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det), .sda_i(sda_s),
    .wc_i, .busy_i(busy), .rd_data_i(rd_data),
    .sda_oe_o, .st_o(st), .ptr_o(ptr),
    .buf_we_o(buf_we), .buf_idx_o(buf_idx), .buf_data_o(buf_data),
    .discard_o(discard), .commit_o(commit), .page_o(page)
  );

  eeprom_store #(
    .MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .BUSY_CYCLES(BUSY_CYCLES)
  ) u_store (
    .clk_i, .rst_ni,
    .buf_we_i(buf_we), .buf_idx_i(buf_idx), .buf_data_i(buf_data),
    .discard_i(discard), .commit_i(commit), .page_i(page),
    .rd_addr_i(ptr), .rd_data_o(rd_data), .busy_o(busy)
  );
endmodule

// File: rtl/serial_eeprom_chk.sv
module serial_eeprom_chk
  import eeprom_pkg::*;
(
  input logic    clk_i,
  input logic    rst_ni,
  input logic    wc_i,
  input logic    sda_oe_o,
  input logic    busy,
  input bus_st_e st,
  input logic    start_det,
  input logic    stop_det
);
  assert_release_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st == ST_IDLE |-> !sda_oe_o);

  assert_start_select_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> st == ST_DEV);

  assert_commit_on_stop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(stop_det));

  assert_busy_locks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (st == ST_IDLE || st == ST_DEV));

  assert_wc_no_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sda_oe_o) && st == ST_WR) |-> !wc_i);

  assert_wc_no_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy) && wc_i) |-> $past(!wc_i));
endmodule

bind serial_eeprom serial_eeprom_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wc_i(wc_i), .sda_oe_o(sda_oe_o),
  .busy(busy), .st(st), .start_det(start_det), .stop_det(stop_det)
);

// File: tb/serial_eeprom_test.sv
module serial_eeprom_test;
  localparam int Q    = 5;
  localparam int BUSY = 400;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, wc = 1'b0;
  logic sda_oe;
  logic sda_bus;
  int   n_run = 0, n_fail = 0;
  logic [7:0] rbuf [4];

  always #2.5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  serial_eeprom #(.MEM_BYTES(1024), .PAGE_BYTES(64), .BUSY_CYCLES(BUSY)) uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .wc_i(wc), .sda_oe_o(sda_oe)
  );

  // {write address, read-back address, data}
  localparam logic [39:0] VEC [4] = '{
    {16'h0000, 16'h0000, 8'hA5},
    {16'h0123, 16'h0123, 8'h3C},
    {16'h03FF, 16'h03FF, 8'h7E},
    {16'h8010, 16'h0010, 8'hC3}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2 * Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    ack = ~sda_bus;
    tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic get_byte(input logic mack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1; tick(Q); d[i] = sda_bus; tick(Q); scl_m = 1'b0;
    end
    tick(Q); sda_m = ~mack; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic begin_write(input logic [15:0] a, output logic ok);
    logic k1, k2, k3;
    i2c_start();
    put_byte(8'hA0, k1);
    put_byte(a[15:8], k2);
    put_byte(a[7:0], k3);
    ok = k1 & k2 & k3;
  endtask

  task automatic rand_read(input logic [15:0] a, input int n);
    logic ok, k;
    begin_write(a, ok);
    chk("R3 address acks", ok, 1'b1);
    i2c_start();
    put_byte(8'hA1, k);
    chk("R9 read select ack", k, 1'b1);
    for (int i = 0; i < n; i++) get_byte(i < n - 1, rbuf[i]);
    i2c_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic ok, k;
    tick(4); rst_n = 1'b1; tick(4);
    chk("R1 sda released", sda_oe, 1'b0);
    rand_read(16'h0200, 1);
    chk("R1 erased byte", rbuf[0], 8'hFF);

    foreach (VEC[v]) begin
      begin_write(VEC[v][39:24], ok);
      chk("R3 write address acks", ok, 1'b1);
      put_byte(VEC[v][7:0], k);
      chk("R4 data ack", k, 1'b1);
      i2c_stop();
      tick(BUSY + 50);
      rand_read(VEC[v][23:8], 1);
      chk("R4 read-back", rbuf[0], VEC[v][7:0]);
    end

    // R10: read across top byte, then current-address read from wrapped pointer
    rand_read(16'h03FE, 2);
    chk("R10 seq byte0", rbuf[0], 8'hFF);
    chk("R10 seq byte1", rbuf[1], 8'h7E);
    i2c_start(); put_byte(8'hA1, k);
    get_byte(1'b0, rbuf[0]);
    tick(2);
    chk("R10 released after NoAck", sda_oe, 1'b0);
    i2c_stop();
    chk("R10 wrap current read", rbuf[0], 8'hA5);
    rand_read(16'h0122, 3);
    chk("R10 seq 0x122", rbuf[0], 8'hFF);
    chk("R10 seq 0x123", rbuf[1], 8'h3C);
    chk("R10 seq 0x124", rbuf[2], 8'hFF);

    // R5: page wrap
    begin_write(16'h003E, ok);
    put_byte(8'h11, k); put_byte(8'h22, k); put_byte(8'h33, k);
    chk("R5 third data ack", k, 1'b1);
    i2c_stop();
    tick(BUSY + 50);
    rand_read(16'h003E, 2);
    chk("R5 0x03E", rbuf[0], 8'h11);
    chk("R5 0x03F", rbuf[1], 8'h22);
    rand_read(16'h0000, 1);
    chk("R5 wrapped to 0x000", rbuf[0], 8'h33);
    rand_read(16'h0040, 1);
    chk("R5 next page untouched", rbuf[0], 8'hFF);

    // R7: busy window nacks select
    begin_write(16'h0050, ok);
    put_byte(8'h5A, k);
    i2c_stop();
    i2c_start(); put_byte(8'hA0, k);
    chk("R7 select nack while busy", k, 1'b0);
    i2c_stop();
    tick(BUSY + 50);
    rand_read(16'h0050, 1);
    chk("R7 byte after busy", rbuf[0], 8'h5A);

    // R8: write control
    wc = 1'b1;
    begin_write(16'h0060, ok);
    chk("R8 address acks with wc", ok, 1'b1);
    put_byte(8'h99, k);
    chk("R8 data nack", k, 1'b0);
    i2c_stop();
    i2c_start(); put_byte(8'hA0, k);
    chk("R8 no busy window", k, 1'b1);
    i2c_stop();
    wc = 1'b0;
    rand_read(16'h0060, 1);
    chk("R8 array unchanged", rbuf[0], 8'hFF);

    // R2: wrong select code
    i2c_start(); put_byte(8'hA2, k);
    chk("R2 wrong code nack", k, 1'b0);
    put_byte(8'h00, k);
    chk("R2 ignored until START", k, 1'b0);
    i2c_stop();

    // R6: write aborted by repeated START
    begin_write(16'h0070, ok);
    put_byte(8'h77, k);
    i2c_start(); put_byte(8'hA0, k);
    chk("R6 no busy after abort", k, 1'b1);
    i2c_stop();
    tick(BUSY + 50);
    rand_read(16'h0070, 1);
    chk("R6 discarded byte", rbuf[0], 8'hFF);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule